// File: doc/BRIEF.md
# Clock-Buffer SMBus Control Slave

This block is the control plane of a two-output differential clock buffer. It sits on an SMBus segment as a slave and serves a six-byte register file through block writes and block reads. From that register file and from a few device pins it derives the controls the analog core needs: the PLL loop-bandwidth select, the PLL-versus-bypass select, and one enable for each output pair.

A block write carries the address with the write bit, a command byte that gives the first register index, a count byte, and then that many data bytes. Each data byte goes to the next register index. A block read starts with the address with the read bit. The slave first returns the value of its byte-count register, then that many bytes taken from index 0 upwards. One bit of the control byte selects where the bandwidth and bypass controls come from. When it is set, they come from the register file. When it is clear, the bandwidth follows a pin and the PLL stays in use. Each output pair is enabled directly by its own active-low request pin.

Both bus lines pass through a two-flop synchroniser and a stability filter before any edge, START or STOP is detected. The slave drives SDA through an open-drain enable only.

Top module: `clkbuf_smb_ctrl`

## Requirements
- R1: The slave acknowledges only the address byte 0xDC (write) or 0xDD (read), which is 7-bit address 0x6E. Any other address byte, for example 0xA0 or 0xDE, is not acknowledged and the slave stays off the bus until the next START.
- R2: In a block write the slave acknowledges the address, the command byte (start index) and the count byte. It then writes each acknowledged data byte to the current index and increments the index by one.
- R3: Index 3 always reads 0x01 (revision in bits 7:4, vendor in bits 3:0) and index 4 always reads 0x06. Writes to these indices are acknowledged and discarded.
- R4: A block read first returns the byte-count register (index 5) and then returns data from index 0 upwards. Indices 6 and above read 0x00.
- R5: The byte-count register (index 5) resets to 0x06, is writable, and sets the number of data bytes a block read returns after the count byte.
- R6: The slave releases SDA after a data byte the master does not acknowledge, and after the last counted byte even if the master acknowledges it. Any further clocked byte then reads 0xFF.
- R7: After reset, index 0 reads 0x83, indices 1 and 2 read 0x00, pll_bw_sel is 1, pll_on is 1, and SDA is not driven.
- R8: When bit 7 of index 0 is 1, pll_bw_sel equals bit 1 of index 0 (1 = high bandwidth) and pll_on equals bit 0 of index 0 (1 = PLL, 0 = bypass).
- R9: When bit 7 of index 0 is 0, pll_bw_sel follows bw_pin (1 = high bandwidth) and pll_on is 1, whatever bits 1 and 0 hold.
- R10: out_en[i] is 1 when req_n[i] is 0 and 0 when req_n[i] is 1, for each output pair.
- R11: A STOP at any point ends the transfer and releases SDA. A START at any point, including a repeated START, restarts address reception, and the following transaction completes normally.
- R12: Bits 6:2 of index 0 and all bits of indices 1 and 2 read back as written.
- R13: Data bytes beyond the count of a block write are not acknowledged and do not change any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, oversamples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_in | input | 1 | SMBus clock line level |
| sda_in | input | 1 | SMBus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| bw_pin | input | 1 | Bandwidth select pin, 1 = high, 0 = low |
| req_n | input | NUM_OUT | Active-low request per output pair |
| out_en | output | NUM_OUT | Enable per output pair, 0 = tri-stated |
| pll_bw_sel | output | 1 | Selected PLL bandwidth, 1 = high |
| pll_on | output | 1 | 1 = PLL mode, 0 = bypass fan-out mode |

## Verification
On every cycle the assertions check three things. SDA is driven only during an acknowledge slot or a slave-transmitted data bit. A STOP always frees the line and a START always resets the bit counter into address reception. A write to the byte-count register lands in the following cycle. The bench scenarios are needed for the rest, because only full bus transactions show it. These cover the acknowledge pattern of matching and foreign addresses, and that read-only and over-count bytes are dropped. They also cover the length and content of block reads as the count register changes, the release after a master NACK, and the recovery after aborted transfers. The pin-versus-register selection of the PLL controls is checked at the output ports after each write.

// File: rtl/scb_pkg.sv
package scb_pkg;
  typedef enum logic [2:0] {
    SB_IDLE, SB_RX, SB_RX_ACK, SB_TX, SB_TX_ACK
  } sb_state_t;

  typedef enum logic [1:0] {
    PH_ADDR, PH_CMD, PH_CNT, PH_DATA
  } sb_phase_t;

  localparam logic [7:0] IDX_CTRL  = 8'd0;
  localparam logic [7:0] IDX_RSV0  = 8'd1;
  localparam int         RSV_N     = 2;
  localparam logic [7:0] IDX_VREV  = 8'd3;
  localparam logic [7:0] IDX_DEVID = 8'd4;
  localparam logic [7:0] IDX_BC    = 8'd5;

  localparam logic [7:0] CTRL_RST  = 8'h83;
  localparam logic [7:0] VREV_VAL  = 8'h01;
  localparam logic [7:0] DEVID_VAL = 8'h06;
  localparam logic [7:0] BC_RST    = 8'h06;

  localparam int SWEN_BIT  = 7;
  localparam int BW_BIT    = 1;
  localparam int PLLEN_BIT = 0;
endpackage

// File: rtl/scb_line_filter.sv
module scb_line_filter #(
  parameter int LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  logic [1:0]     sync_q;
  logic [LEN-1:0] hist_q;
  logic           filt_d;

  always_comb begin
    if (&hist_q)      filt_d = 1'b1;
    else if (|hist_q) filt_d = filt;
    else              filt_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= '1;
      filt   <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], raw};
      hist_q <= {hist_q[LEN-2:0], sync_q[1]};
      filt   <= filt_d;
    end
  end
endmodule

// File: rtl/scb_regfile.sv
module scb_regfile
  import scb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_idx,
  input  logic [7:0] wr_data,
  input  logic [7:0] rd_idx,
  output logic [7:0] rd_data,
  output logic [7:0] bc_val,
  output logic       sw_en,
  output logic       bw_reg,
  output logic       pll_reg
);
  logic [7:0] ctrl_q;
  logic [7:0] bc_q;
  logic [7:0] rsv_q [RSV_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      bc_q   <= BC_RST;
    end else begin
      if (wr_en && wr_idx == IDX_CTRL) ctrl_q <= wr_data;
      if (wr_en && wr_idx == IDX_BC)   bc_q   <= wr_data;
    end
  end

  for (genvar g = 0; g < RSV_N; g++) begin : g_rsv
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rsv_q[g] <= 8'h00;
      else if (wr_en && wr_idx == 8'(IDX_RSV0 + g)) rsv_q[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_idx == IDX_CTRL)  rd_data = ctrl_q;
    for (int k = 0; k < RSV_N; k++)
      if (rd_idx == 8'(IDX_RSV0 + k)) rd_data = rsv_q[k];
    if (rd_idx == IDX_VREV)  rd_data = VREV_VAL;
    if (rd_idx == IDX_DEVID) rd_data = DEVID_VAL;
    if (rd_idx == IDX_BC)    rd_data = bc_q;
  end

  assign bc_val  = bc_q;
  assign sw_en   = ctrl_q[SWEN_BIT];
  assign bw_reg  = ctrl_q[BW_BIT];
  assign pll_reg = ctrl_q[PLLEN_BIT];

  // R5
  bc_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IDX_BC) |=> (bc_q == $past(wr_data)));
endmodule

// File: rtl/scb_ctrl_sel.sv
module scb_ctrl_sel #(
  parameter int NUM_OUT = 2
) (
  input  logic               sw_en,
  input  logic               bw_reg,
  input  logic               pll_reg,
  input  logic               bw_pin,
  input  logic [NUM_OUT-1:0] req_n,
  output logic [NUM_OUT-1:0] out_en,
  output logic               pll_bw_sel,
  output logic               pll_on
);
  assign pll_bw_sel = sw_en ? bw_reg  : bw_pin;
  assign pll_on     = sw_en ? pll_reg : 1'b1;

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_oe
    assign out_en[g] = ~req_n[g];
  end
endmodule

// File: rtl/clkbuf_smb_ctrl.sv
module clkbuf_smb_ctrl
  import scb_pkg::*;
#(
  parameter logic [6:0] ADDR7    = 7'h6E,
  parameter int         FILT_LEN = 3,
  parameter int         NUM_OUT  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_oe,
  input  logic               bw_pin,
  input  logic [NUM_OUT-1:0] req_n,
  output logic [NUM_OUT-1:0] out_en,
  output logic               pll_bw_sel,
  output logic               pll_on
);
  logic [1:0] rst_pipe;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_i = rst_pipe[1];

  logic scl_f, sda_f, scl_p, sda_p;
  scb_line_filter #(.LEN(FILT_LEN)) u_scl_filt (
    .clk(clk), .rst_n(rst_n_i), .raw(scl_in), .filt(scl_f));
  scb_line_filter #(.LEN(FILT_LEN)) u_sda_filt (
    .clk(clk), .rst_n(rst_n_i), .raw(sda_in), .filt(sda_f));

  logic scl_rise, scl_fall, start_det, stop_det;
  assign scl_rise  = scl_f & ~scl_p;
  assign scl_fall  = ~scl_f & scl_p;
  assign start_det = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_det  = scl_f & scl_p & ~sda_p & sda_f;

  sb_state_t  st_q, st_d;
  sb_phase_t  ph_q, ph_d;
  logic [7:0] sh_q, sh_d, idx_q, idx_d, wl_q, wl_d, rl_q, rl_d;
  logic [3:0] bit_q, bit_d;
  logic       rdm_q, rdm_d, drv_q, drv_d, mack_q, mack_d;
  logic       wr_en;
  logic [7:0] rd_byte, bc_val;
  logic       sw_en, bw_reg, pll_reg;

  always_comb begin
    st_d = st_q;   ph_d = ph_q;   sh_d = sh_q;   bit_d = bit_q;
    idx_d = idx_q; wl_d = wl_q;   rl_d = rl_q;   rdm_d = rdm_q;
    drv_d = drv_q; mack_d = mack_q; wr_en = 1'b0;
    if (start_det) begin
      st_d = SB_RX; ph_d = PH_ADDR; bit_d = 4'd0; drv_d = 1'b0; rdm_d = 1'b0;
    end else if (stop_det) begin
      st_d = SB_IDLE; drv_d = 1'b0;
    end else begin
      case (st_q)
        SB_RX: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_f};
            bit_d = bit_q + 4'd1;
          end else if (scl_fall && bit_q == 4'd8) begin
            bit_d = 4'd0; st_d = SB_RX_ACK; drv_d = 1'b1;
            case (ph_q)
              PH_ADDR: begin
                if (sh_q[7:1] != ADDR7) begin
                  st_d = SB_IDLE; drv_d = 1'b0;
                end else begin
                  rdm_d = sh_q[0]; ph_d = PH_CMD;
                end
              end
              PH_CMD: begin idx_d = sh_q; ph_d = PH_CNT; end
              PH_CNT: begin wl_d = sh_q; ph_d = PH_DATA; end
              default: begin
                if (wl_q == 8'd0) begin
                  st_d = SB_IDLE; drv_d = 1'b0;
                end else begin
                  wr_en = 1'b1; idx_d = idx_q + 8'd1; wl_d = wl_q - 8'd1;
                end
              end
            endcase
          end
        end
        SB_RX_ACK: begin
          if (scl_fall) begin
            drv_d = 1'b0;
            if (rdm_q) begin
              st_d = SB_TX; sh_d = bc_val; drv_d = ~bc_val[7];
              idx_d = 8'd0; rl_d = bc_val;
            end else begin
              st_d = SB_RX;
            end
          end
        end
        SB_TX: begin
          if (scl_rise) begin
            bit_d = bit_q + 4'd1;
          end else if (scl_fall) begin
            if (bit_q == 4'd8) begin
              st_d = SB_TX_ACK; drv_d = 1'b0; bit_d = 4'd0;
            end else begin
              sh_d = {sh_q[6:0], 1'b0}; drv_d = ~sh_q[6];
            end
          end
        end
        SB_TX_ACK: begin
          if (scl_rise) begin
            mack_d = ~sda_f;
          end else if (scl_fall) begin
            if (mack_q && rl_q != 8'd0) begin
              st_d = SB_TX; sh_d = rd_byte; drv_d = ~rd_byte[7];
              idx_d = idx_q + 8'd1; rl_d = rl_q - 8'd1;
            end else begin
              st_d = SB_IDLE; drv_d = 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st_q <= SB_IDLE; ph_q <= PH_ADDR; sh_q <= 8'h00; bit_q <= 4'd0;
      idx_q <= 8'h00; wl_q <= 8'h00; rl_q <= 8'h00; rdm_q <= 1'b0;
      drv_q <= 1'b0; mack_q <= 1'b0; scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      st_q <= st_d; ph_q <= ph_d; sh_q <= sh_d; bit_q <= bit_d;
      idx_q <= idx_d; wl_q <= wl_d; rl_q <= rl_d; rdm_q <= rdm_d;
      drv_q <= drv_d; mack_q <= mack_d; scl_p <= scl_f; sda_p <= sda_f;
    end
  end

  assign sda_oe = drv_q;

  scb_regfile u_regs (
    .clk(clk), .rst_n(rst_n_i), .wr_en(wr_en), .wr_idx(idx_q),
    .wr_data(sh_q), .rd_idx(idx_q), .rd_data(rd_byte), .bc_val(bc_val),
    .sw_en(sw_en), .bw_reg(bw_reg), .pll_reg(pll_reg));

  scb_ctrl_sel #(.NUM_OUT(NUM_OUT)) u_sel (
    .sw_en(sw_en), .bw_reg(bw_reg), .pll_reg(pll_reg), .bw_pin(bw_pin),
    .req_n(req_n), .out_en(out_en), .pll_bw_sel(pll_bw_sel), .pll_on(pll_on));

  // R11
  stop_rel_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    stop_det |=> !sda_oe);
  // R11
  start_rx_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    start_det |=> (st_q == SB_RX && bit_q == 4'd0));
  // R6
  drive_slot_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    sda_oe |-> (st_q == SB_RX_ACK || st_q == SB_TX));
  // R2
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    bit_q <= 4'd8);
endmodule

// File: tb/clkbuf_smb_ctrl_bench.sv
module clkbuf_smb_ctrl_bench;
  localparam int Q = 12;

  logic       clk = 1'b0;
  logic       rst_n, scl, m_sda, bw_pin;
  logic [1:0] req_n;
  logic       sda_oe, pll_bw_sel, pll_on;
  logic [1:0] out_en;
  wire        sda_line = m_sda & ~sda_oe;

  int n_chk = 0, n_fail = 0;
  logic [7:0] model [0:5];
  logic [7:0] wbuf [0:7];

  always #2.5 clk = ~clk;

  clkbuf_smb_ctrl u_clkbuf_smb_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
    .sda_oe(sda_oe), .bw_pin(bw_pin), .req_n(req_n), .out_en(out_en),
    .pll_bw_sel(pll_bw_sel), .pll_on(pll_on));

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic start_c();
    m_sda = 1'b1; qwait(); scl = 1'b1; qwait();
    m_sda = 1'b0; qwait(); scl = 1'b0; qwait();
  endtask

  task automatic stop_c();
    m_sda = 1'b0; qwait(); scl = 1'b1; qwait(); m_sda = 1'b1; qwait();
  endtask

  task automatic bit_io(input logic b, output logic s);
    m_sda = b; qwait(); scl = 1'b1; qwait();
    s = sda_line; qwait(); scl = 1'b0; qwait();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic mack);
    logic s;
    b = 8'h00;
    for (int i = 0; i < 8; i++) begin bit_io(1'b1, s); b = {b[6:0], s}; end
    bit_io(~mack, s);
  endtask

  // block write of nd bytes from wbuf; checks the ack pattern, updates model
  task automatic wr_blk(string req, logic [7:0] cmd, logic [7:0] cnt, int nd);
    logic a;
    logic [15:0] act, exp;
    act = '0; exp = '0;
    start_c();
    send_byte(8'hDC, a); act[0] = a; exp[0] = 1'b1;
    send_byte(cmd, a);   act[1] = a; exp[1] = 1'b1;
    send_byte(cnt, a);   act[2] = a; exp[2] = 1'b1;
    for (int i = 0; i < nd; i++) begin
      send_byte(wbuf[i], a);
      act[3+i] = a;
      exp[3+i] = (i < int'(cnt));
      if (i < int'(cnt)) begin
        int idx = int'(cmd) + i;
        if (idx == 0 || idx == 1 || idx == 2 || idx == 5) model[idx] = wbuf[i];
      end
    end
    stop_c();
    chk(req, "write ack pattern", int'(act), int'(exp));
  endtask

  // block read of the full count; every byte compared with the model
  task automatic rd_check(string req);
    logic a;
    logic [7:0] b, bc;
    start_c();
    send_byte(8'hDD, a);
    chk(req, "read address ack", int'(a), 1);
    bc = model[5];
    recv_byte(b, bc != 8'd0);
    chk(req, "count byte", int'(b), int'(bc));
    for (int i = 0; i < int'(bc); i++) begin
      recv_byte(b, i < int'(bc) - 1);
      chk(req, $sformatf("read data idx %0d", i), int'(b),
          (i < 6) ? int'(model[i]) : 0);
    end
    stop_c();
  endtask

  task automatic t_reset();
    chk("R7", "sda_oe after reset", int'(sda_oe), 0);
    chk("R7", "pll_bw_sel after reset", int'(pll_bw_sel), 1);
    chk("R7", "pll_on after reset", int'(pll_on), 1);
    rd_check("R7 R4 R5");
  endtask

  task automatic t_address();
    logic a;
    start_c(); send_byte(8'hA0, a); stop_c();
    chk("R1", "foreign address 0xA0 ack", int'(a), 0);
    start_c(); send_byte(8'hDE, a);
    chk("R1", "foreign address 0xDE ack", int'(a), 0);
    send_byte(8'h00, a);
    chk("R1", "byte after foreign address ack", int'(a), 0);
    stop_c();
    start_c(); send_byte(8'hDC, a); stop_c();
    chk("R1", "own write address ack", int'(a), 1);
  endtask

  task automatic t_write();
    wbuf[0] = 8'hAA; wbuf[1] = 8'h55;
    wr_blk("R2", 8'd1, 8'd2, 2);
    rd_check("R2 R12");
  endtask

  task automatic t_readonly();
    wbuf[0] = 8'hFF; wbuf[1] = 8'hFF; wbuf[2] = 8'h09;
    wr_blk("R3", 8'd3, 8'd3, 3);
    rd_check("R3 R4 R5");
  endtask

  task automatic t_overcount();
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    wr_blk("R13", 8'd1, 8'd1, 3);
    rd_check("R13");
  endtask

  task automatic t_swctrl();
    wbuf[0] = 8'hFC;
    wr_blk("R8", 8'd0, 8'd1, 1);
    chk("R8", "bw from register 0", int'(pll_bw_sel), 0);
    chk("R8", "bypass from register", int'(pll_on), 0);
    rd_check("R12");
    bw_pin = 1'b1; repeat (4) @(negedge clk);
    chk("R8", "pin ignored in register mode", int'(pll_bw_sel), 0);
    wbuf[0] = 8'h81;
    wr_blk("R8", 8'd0, 8'd1, 1);
    chk("R8", "bw low, pll on", int'(pll_bw_sel), 0);
    chk("R8", "pll on from register", int'(pll_on), 1);
    wbuf[0] = 8'h82;
    wr_blk("R8", 8'd0, 8'd1, 1);
    chk("R8", "bw high from register", int'(pll_bw_sel), 1);
    chk("R8", "bypass with high bw", int'(pll_on), 0);
  endtask

  task automatic t_pinctrl();
    wbuf[0] = 8'h00;
    bw_pin = 1'b0;
    wr_blk("R9", 8'd0, 8'd1, 1);
    chk("R9", "bw follows pin low", int'(pll_bw_sel), 0);
    chk("R9", "pll on in pin mode", int'(pll_on), 1);
    bw_pin = 1'b1; repeat (4) @(negedge clk);
    chk("R9", "bw follows pin high", int'(pll_bw_sel), 1);
    chk("R9", "pll on in pin mode, pin high", int'(pll_on), 1);
  endtask

  task automatic t_release();
    logic a;
    logic [7:0] b;
    wbuf[0] = 8'h06;
    wr_blk("R5", 8'd5, 8'd1, 1);
    start_c(); send_byte(8'hDD, a);
    recv_byte(b, 1'b1);
    chk("R5", "count byte back to 6", int'(b), 6);
    recv_byte(b, 1'b1);
    recv_byte(b, 1'b0);
    chk("R6", "second data byte", int'(b), int'(model[1]));
    recv_byte(b, 1'b0);
    chk("R6", "byte after master NACK", int'(b), 8'hFF);
    stop_c();
    wbuf[0] = 8'h02;
    wr_blk("R5", 8'd5, 8'd1, 1);
    start_c(); send_byte(8'hDD, a);
    recv_byte(b, 1'b1);
    chk("R5", "count byte 2", int'(b), 2);
    recv_byte(b, 1'b1);
    recv_byte(b, 1'b1);
    chk("R5", "last counted byte", int'(b), int'(model[1]));
    recv_byte(b, 1'b0);
    chk("R6", "byte after count exhausted", int'(b), 8'hFF);
    stop_c();
  endtask

  task automatic t_abort();
    logic a, s;
    start_c(); send_byte(8'hDC, a); send_byte(8'h02, a); send_byte(8'h01, a);
    stop_c();
    chk("R11", "SDA free after stop", int'(sda_line), 1);
    start_c(); send_byte(8'hDC, a);
    for (int i = 0; i < 4; i++) bit_io(1'b0, s);
    stop_c();
    chk("R11", "SDA free after mid-byte stop", int'(sda_line), 1);
    start_c(); send_byte(8'hDC, a); send_byte(8'h02, a); send_byte(8'h02, a);
    send_byte(8'h44, a);
    chk("R11", "data ack before stop", int'(a), 1);
    model[2] = 8'h44;
    stop_c();
    start_c(); send_byte(8'hDC, a); send_byte(8'h01, a);
    rd_check("R11");
  endtask

  task automatic t_request();
    req_n = 2'b00; repeat (2) @(negedge clk);
    chk("R10", "both requested", int'(out_en), 2'b11);
    req_n = 2'b01; repeat (2) @(negedge clk);
    chk("R10", "pair 1 only", int'(out_en), 2'b10);
    req_n = 2'b10; repeat (2) @(negedge clk);
    chk("R10", "pair 0 only", int'(out_en), 2'b01);
    req_n = 2'b11; repeat (2) @(negedge clk);
    chk("R10", "none requested", int'(out_en), 2'b00);
  endtask

  initial begin
    rst_n = 1'b0; scl = 1'b1; m_sda = 1'b1; bw_pin = 1'b1; req_n = 2'b00;
    model[0] = 8'h83; model[1] = 8'h00; model[2] = 8'h00;
    model[3] = 8'h01; model[4] = 8'h06; model[5] = 8'h06;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    t_reset();
    t_address();
    t_write();
    t_readonly();
    t_overcount();
    t_swctrl();
    t_pinctrl();
    t_release();
    t_abort();
    t_request();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule